// File: doc/BRIEF.md
# DSP subsystem power sequencer

This block walks the power domain of a DSP subsystem between fully off and running, in a fixed order. A start command brings the domain up. The block takes the core into reset and releases the subsystem reset. It then enables the oscillator clock branch and turns on the head switch and the regulator bypass. Next it lifts the memory clamps and releases standby and retention. It powers the memory banks one at a time, removes the remaining clamps, and finally lets the core run. A stop command brings the domain down in reverse fashion and ends with the subsystem and core held in reset.

Settle delays are counted in pulses of a `tick` input, so the time base is whatever the chip feeds it. Two status inputs are polled with a bounded number of tick-paced retries: the clock branch's clock-off flag during power-up, and the head-switch reset acknowledge during power-down. If either poll runs out, the sequence stops with an error and every control output holds its value. It stays there until reset or a new command. The bus halt is handled outside the block: a stop command means the bus is already quiet.

Top module: `dsp_pwr_seq`

## Requirements
- R1: After reset: core_rst, bus_rst, core_stop, subsys_rst, qmc_clamp, wl_clamp and io_clamp are 1. All other controls, bank_pwr, done, busy and err are 0.
- R2: A start command is taken at a clock edge only while busy is 0. The first step asserts core_rst, bus_rst and core_stop and releases subsys_rst, all in the same edge.
- R3: The next step sets xo_clk_en. The block then waits for clk_off to read 0. Each tick seen while clk_off is 1 counts as a failed poll, and the POLL_LIMIT-th failed poll ends the sequence with err.
- R4: After the poll succeeds, the steps run in this order: hs_on is set, HS_SETTLE ticks pass, ldo_byp is set, qmc_clamp is cleared, and then l2_stby_rel and ret_rel are set together.
- R5: During power-up the banks turn on one bit per step, from index NUM_BANKS-1 down to 0. Each bit is followed by BANK_UP_SETTLE ticks.
- R6: Power-up then clears wl_clamp, clears io_clamp, clears core_rst, sets core_clk_en and clears core_stop, one step per clock in that order. After that busy falls and done rises.
- R7: A stop command is taken only while busy is 0. Power-down first clears core_clk_en, then sets io_clamp, then clears l2_stby_rel, then clears ret_rel, one step per clock.
- R8: During power-down the banks turn off one bit per step, from index 0 up to NUM_BANKS-1, each followed by BANK_DN_SETTLE ticks. Then qmc_clamp is set, and after that hs_on is cleared.
- R9: After hs_on is cleared, the block waits for hs_rst_ack to read 0, with the same tick-paced POLL_LIMIT bound as R3. It then sets subsys_rst, and in the next step sets core_rst, and completes.
- R10: A stop command seen during power-up is held. Power-down starts on the clock right after the last power-up step, and done stays 0 in between. Start commands during power-up, and start or stop commands during power-down, have no effect.
- R11: On a poll timeout, err rises and busy stays 0. All outputs then hold until a command arrives. A command clears err. If start and stop arrive in the same idle cycle, stop wins.
- R12: busy is 1 from the clock edge that accepts a command until the sequence completes or fails. done is 0 while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base pulse for settle delays and polls |
| start_cmd | input | 1 | Power-up request |
| stop_cmd | input | 1 | Power-down request (bus already halted) |
| clk_off | input | 1 | Oscillator branch clock-off status, 0 when the clock runs |
| hs_rst_ack | input | 1 | Head-switch reset acknowledge, 0 when the switch is off |
| core_rst | output | 1 | Core reset |
| bus_rst | output | 1 | Core bus reset enable |
| core_stop | output | 1 | Core execution stop |
| subsys_rst | output | 1 | Subsystem reset |
| xo_clk_en | output | 1 | Oscillator clock branch enable |
| hs_on | output | 1 | Head switch enable |
| ldo_byp | output | 1 | Regulator bypass |
| qmc_clamp | output | 1 | Compiler-memory clamp |
| wl_clamp | output | 1 | Word-line clamp |
| io_clamp | output | 1 | IO clamp |
| l2_stby_rel | output | 1 | L2 data standby release |
| ret_rel | output | 1 | Sleep retention release |
| bank_pwr | output | NUM_BANKS | Per-bank memory power enables |
| core_clk_en | output | 1 | Core clock enable |
| done | output | 1 | Last sequence completed |
| busy | output | 1 | Sequence in progress |
| err | output | 1 | Last sequence timed out |

## Verification
On every cycle, the assertions check the safety relations between outputs. Bank enables change at most one bit per clock and are only on while the head switch is on. The core clock never runs while the core is in reset, and bypass only rises with the head switch on. An error state holds every output and never coexists with busy or done. The exact order and timing of the steps, the tick-counted settle windows, the poll limits, a held stop merging into power-down, and ignored commands are shown only by the bench's scenarios. There, a behavioural model of the sequence is compared with every output on every clock.

// File: rtl/dsp_pwr_seq.sv
module dsp_pwr_seq #(
  parameter int NUM_BANKS      = 20,
  parameter int HS_SETTLE      = 1,
  parameter int BANK_UP_SETTLE = 1,
  parameter int BANK_DN_SETTLE = 1000,
  parameter int POLL_LIMIT     = 200
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 start_cmd,
  input  logic                 stop_cmd,
  input  logic                 clk_off,
  input  logic                 hs_rst_ack,
  output logic                 core_rst,
  output logic                 bus_rst,
  output logic                 core_stop,
  output logic                 subsys_rst,
  output logic                 xo_clk_en,
  output logic                 hs_on,
  output logic                 ldo_byp,
  output logic                 qmc_clamp,
  output logic                 wl_clamp,
  output logic                 io_clamp,
  output logic                 l2_stby_rel,
  output logic                 ret_rel,
  output logic [NUM_BANKS-1:0] bank_pwr,
  output logic                 core_clk_en,
  output logic                 done,
  output logic                 busy,
  output logic                 err
);
  localparam int WMAX0 = (HS_SETTLE > BANK_UP_SETTLE) ? HS_SETTLE : BANK_UP_SETTLE;
  localparam int WMAX  = (WMAX0 > BANK_DN_SETTLE) ? WMAX0 : BANK_DN_SETTLE;
  localparam int WW    = $clog2(WMAX + 1);
  localparam int PW    = $clog2(POLL_LIMIT + 1);
  localparam int IW    = $clog2(NUM_BANKS);

  typedef enum logic [4:0] {
    S_IDLE,
    U_RST, U_XO, U_XOP, U_HS, U_HSW, U_LDO, U_QMC, U_MEM, U_BK, U_BKW,
    U_WL, U_IO, U_CORE, U_CLK, U_GO,
    D_CLK, D_IO, D_STBY, D_RET, D_BK, D_BKW, D_QMC, D_HS, D_ACKP, D_SS, D_CORE
  } st_t;

  st_t          st;
  logic [WW-1:0] wcnt;
  logic [PW-1:0] pcnt;
  logic [IW-1:0] idx;
  logic          stop_pend;
  logic          up_phase;
  logic          wait_hit;
  logic          poll_out;
  int            wait_lim;

  assign up_phase = (st >= U_RST) && (st <= U_GO);
  assign poll_out = tick && (pcnt == PW'(POLL_LIMIT - 1));
  assign wait_hit = tick && (wcnt == WW'(wait_lim - 1));

  always_comb begin
    case (st)
      U_HSW:   wait_lim = HS_SETTLE;
      U_BKW:   wait_lim = BANK_UP_SETTLE;
      default: wait_lim = BANK_DN_SETTLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      wcnt <= '0;
      pcnt <= '0;
      idx <= '0;
      stop_pend <= 1'b0;
      core_rst <= 1'b1;
      bus_rst <= 1'b1;
      core_stop <= 1'b1;
      subsys_rst <= 1'b1;
      xo_clk_en <= 1'b0;
      hs_on <= 1'b0;
      ldo_byp <= 1'b0;
      qmc_clamp <= 1'b1;
      wl_clamp <= 1'b1;
      io_clamp <= 1'b1;
      l2_stby_rel <= 1'b0;
      ret_rel <= 1'b0;
      bank_pwr <= '0;
      core_clk_en <= 1'b0;
      done <= 1'b0;
      busy <= 1'b0;
      err <= 1'b0;
    end else begin
      if (up_phase && stop_cmd) stop_pend <= 1'b1;
      case (st)
        S_IDLE: begin
          if (stop_cmd || start_cmd) begin
            busy <= 1'b1;
            done <= 1'b0;
            err  <= 1'b0;
            st   <= stop_cmd ? D_CLK : U_RST;
          end
        end
        U_RST: begin
          core_rst <= 1'b1;
          bus_rst <= 1'b1;
          core_stop <= 1'b1;
          subsys_rst <= 1'b0;
          st <= U_XO;
        end
        U_XO: begin
          xo_clk_en <= 1'b1;
          st <= U_XOP;
        end
        U_XOP: begin
          if (!clk_off) begin
            pcnt <= '0;
            st <= U_HS;
          end else if (poll_out) begin
            pcnt <= '0;
            stop_pend <= 1'b0;
            busy <= 1'b0;
            err <= 1'b1;
            st <= S_IDLE;
          end else if (tick) begin
            pcnt <= pcnt + 1'b1;
          end
        end
        U_HS: begin
          hs_on <= 1'b1;
          st <= U_HSW;
        end
        U_LDO: begin
          ldo_byp <= 1'b1;
          st <= U_QMC;
        end
        U_QMC: begin
          qmc_clamp <= 1'b0;
          st <= U_MEM;
        end
        U_MEM: begin
          l2_stby_rel <= 1'b1;
          ret_rel <= 1'b1;
          idx <= IW'(NUM_BANKS - 1);
          st <= U_BK;
        end
        U_BK: begin
          bank_pwr[idx] <= 1'b1;
          st <= U_BKW;
        end
        U_HSW, U_BKW, D_BKW: begin
          if (wait_hit) begin
            wcnt <= '0;
            case (st)
              U_HSW: st <= U_LDO;
              U_BKW: begin
                if (idx == '0) st <= U_WL;
                else begin
                  idx <= idx - 1'b1;
                  st <= U_BK;
                end
              end
              default: begin
                if (idx == IW'(NUM_BANKS - 1)) st <= D_QMC;
                else begin
                  idx <= idx + 1'b1;
                  st <= D_BK;
                end
              end
            endcase
          end else if (tick) begin
            wcnt <= wcnt + 1'b1;
          end
        end
        U_WL: begin
          wl_clamp <= 1'b0;
          st <= U_IO;
        end
        U_IO: begin
          io_clamp <= 1'b0;
          st <= U_CORE;
        end
        U_CORE: begin
          core_rst <= 1'b0;
          st <= U_CLK;
        end
        U_CLK: begin
          core_clk_en <= 1'b1;
          st <= U_GO;
        end
        U_GO: begin
          core_stop <= 1'b0;
          stop_pend <= 1'b0;
          if (stop_pend || stop_cmd) st <= D_CLK;
          else begin
            busy <= 1'b0;
            done <= 1'b1;
            st <= S_IDLE;
          end
        end
        D_CLK: begin
          core_clk_en <= 1'b0;
          st <= D_IO;
        end
        D_IO: begin
          io_clamp <= 1'b1;
          st <= D_STBY;
        end
        D_STBY: begin
          l2_stby_rel <= 1'b0;
          st <= D_RET;
        end
        D_RET: begin
          ret_rel <= 1'b0;
          idx <= '0;
          st <= D_BK;
        end
        D_BK: begin
          bank_pwr[idx] <= 1'b0;
          st <= D_BKW;
        end
        D_QMC: begin
          qmc_clamp <= 1'b1;
          st <= D_HS;
        end
        D_HS: begin
          hs_on <= 1'b0;
          st <= D_ACKP;
        end
        D_ACKP: begin
          if (!hs_rst_ack) begin
            pcnt <= '0;
            st <= D_SS;
          end else if (poll_out) begin
            pcnt <= '0;
            busy <= 1'b0;
            err <= 1'b1;
            st <= S_IDLE;
          end else if (tick) begin
            pcnt <= pcnt + 1'b1;
          end
        end
        D_SS: begin
          subsys_rst <= 1'b1;
          st <= D_CORE;
        end
        D_CORE: begin
          core_rst <= 1'b1;
          busy <= 1'b0;
          done <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_ONE_BANK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($countones(bank_pwr ^ $past(bank_pwr)) <= 1)) else $error("bank step"); // R5

  AST_BANK_NEEDS_HS: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_pwr != '0) |-> hs_on) else $error("bank without head switch"); // R8

  AST_LDO_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ldo_byp) |-> hs_on) else $error("bypass before head switch"); // R4

  AST_CLK_OUT_OF_RST: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en |-> !core_rst) else $error("clock in reset"); // R6

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !done)) else $error("error with busy or done"); // R11

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start_cmd && !stop_cmd) |=> $stable({core_rst, bus_rst, core_stop, subsys_rst,
      xo_clk_en, hs_on, ldo_byp, qmc_clamp, wl_clamp, io_clamp, l2_stby_rel, ret_rel,
      bank_pwr, core_clk_en, err})) else $error("outputs moved in error"); // R11
endmodule

// File: tb/dsp_pwr_seq_bench.sv
module dsp_pwr_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 20;
  localparam int HS = 2;
  localparam int UP = 3;
  localparam int DN = 5;
  localparam int PL = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic start_cmd = 1'b0;
  logic stop_cmd = 1'b0;
  logic clk_off = 1'b0;
  logic hs_rst_ack = 1'b0;
  logic core_rst, bus_rst, core_stop, subsys_rst, xo_clk_en, hs_on, ldo_byp;
  logic qmc_clamp, wl_clamp, io_clamp, l2_stby_rel, ret_rel, core_clk_en, done, busy, err;
  logic [NB-1:0] bank_pwr;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic e_core_rst = 1, e_bus_rst = 1, e_core_stop = 1, e_subsys_rst = 1, e_xo = 0, e_hs = 0;
  logic e_ldo = 0, e_qmc = 1, e_wl = 1, e_io = 1, e_stby = 0, e_ret = 0, e_clk = 0;
  logic e_done = 0, e_busy = 0, e_err = 0;
  logic [NB-1:0] e_bank = '0;
  bit m_up = 0, m_pend = 0;

  dsp_pwr_seq #(.NUM_BANKS(NB), .HS_SETTLE(HS), .BANK_UP_SETTLE(UP),
                .BANK_DN_SETTLE(DN), .POLL_LIMIT(PL)) u_dsp_pwr_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .clk_off(clk_off), .hs_rst_ack(hs_rst_ack), .core_rst(core_rst), .bus_rst(bus_rst),
    .core_stop(core_stop), .subsys_rst(subsys_rst), .xo_clk_en(xo_clk_en), .hs_on(hs_on),
    .ldo_byp(ldo_byp), .qmc_clamp(qmc_clamp), .wl_clamp(wl_clamp), .io_clamp(io_clamp),
    .l2_stby_rel(l2_stby_rel), .ret_rel(ret_rel), .bank_pwr(bank_pwr),
    .core_clk_en(core_clk_en), .done(done), .busy(busy), .err(err));

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // reference model of the sequence
  task automatic edge_();
    @(posedge clk);
    if (m_up && stop_cmd) m_pend = 1;
  endtask

  task automatic settle(int n);
    int c = 0;
    while (c < n) begin
      edge_();
      if (tick) c++;
    end
  endtask

  task automatic poll(bit use_ack, output bit ok);
    int c = 0;
    forever begin
      edge_();
      if ((use_ack ? hs_rst_ack : clk_off) == 1'b0) begin ok = 1; return; end
      if (tick) begin
        c++;
        if (c == PL) begin ok = 0; return; end
      end
    end
  endtask

  task automatic fail_seq();
    e_err = 1; e_busy = 0; m_up = 0; m_pend = 0;
  endtask

  task automatic run_down();
    bit ok;
    edge_(); e_clk = 0;
    edge_(); e_io = 1;
    edge_(); e_stby = 0;
    edge_(); e_ret = 0;
    for (int i = 0; i < NB; i++) begin
      edge_(); e_bank[i] = 0;
      settle(DN);
    end
    edge_(); e_qmc = 1;
    edge_(); e_hs = 0;
    poll(1, ok);
    if (!ok) begin fail_seq(); return; end
    edge_(); e_subsys_rst = 1;
    edge_(); e_core_rst = 1; e_busy = 0; e_done = 1;
  endtask

  task automatic run_up();
    bit ok;
    m_up = 1; m_pend = 0;
    edge_(); e_core_rst = 1; e_bus_rst = 1; e_core_stop = 1; e_subsys_rst = 0;
    edge_(); e_xo = 1;
    poll(0, ok);
    if (!ok) begin fail_seq(); return; end
    edge_(); e_hs = 1;
    settle(HS);
    edge_(); e_ldo = 1;
    edge_(); e_qmc = 0;
    edge_(); e_stby = 1; e_ret = 1;
    for (int i = NB - 1; i >= 0; i--) begin
      edge_(); e_bank[i] = 1;
      settle(UP);
    end
    edge_(); e_wl = 0;
    edge_(); e_io = 0;
    edge_(); e_core_rst = 0;
    edge_(); e_clk = 1;
    edge_(); e_core_stop = 0; m_up = 0;
    if (m_pend) begin m_pend = 0; run_down(); end
    else begin e_busy = 0; e_done = 1; end
  endtask

  initial begin : model
    wait (rst_n === 1'b1);
    forever begin
      edge_();
      if (!e_busy && (stop_cmd || start_cmd)) begin
        e_busy = 1; e_done = 0; e_err = 0;
        if (stop_cmd) run_down(); else run_up();
      end
    end
  end

  // per-cycle comparison against the model
  initial begin : compare
    forever begin
      @(negedge clk);
      if (rst_n && !finished) begin
        chk("R2", "core_rst", core_rst, e_core_rst);
        chk("R2", "bus_rst", bus_rst, e_bus_rst);
        chk("R6", "core_stop", core_stop, e_core_stop);
        chk("R9", "subsys_rst", subsys_rst, e_subsys_rst);
        chk("R3", "xo_clk_en", xo_clk_en, e_xo);
        chk("R4", "hs_on", hs_on, e_hs);
        chk("R4", "ldo_byp", ldo_byp, e_ldo);
        chk("R8", "qmc_clamp", qmc_clamp, e_qmc);
        chk("R6", "wl_clamp", wl_clamp, e_wl);
        chk("R7", "io_clamp", io_clamp, e_io);
        chk("R7", "l2_stby_rel", l2_stby_rel, e_stby);
        chk("R4", "ret_rel", ret_rel, e_ret);
        chk("R5", "bank_pwr", bank_pwr, e_bank);
        chk("R7", "core_clk_en", core_clk_en, e_clk);
        chk("R12", "done", done, e_done);
        chk("R12", "busy", busy, e_busy);
        chk("R11", "err", err, e_err);
      end
    end
  end

  initial begin : tick_gen
    int n = 0;
    forever begin
      @(negedge clk);
      n++;
      tick = (n % 3 == 0);
    end
  end

  task automatic pulse(bit st, bit sp);
    @(negedge clk);
    start_cmd = st; stop_cmd = sp;
    @(negedge clk);
    start_cmd = 0; stop_cmd = 0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (!busy) return;
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "reset resets", {core_rst, bus_rst, core_stop, subsys_rst}, 4'hF);
    chk("R1", "reset clamps", {qmc_clamp, wl_clamp, io_clamp}, 3'h7);
    chk("R1", "reset rest", {xo_clk_en, hs_on, ldo_byp, l2_stby_rel, ret_rel, core_clk_en,
                             done, busy, err}, 9'h0);
    chk("R1", "reset banks", bank_pwr, '0);

    // power-up with clock-off flag high for a while
    clk_off = 1;
    pulse(1, 0);
    repeat (20) @(negedge clk);
    clk_off = 0;
    wait_idle();
    chk("R6", "up done", {done, busy, err, core_stop, core_clk_en}, 5'b10001);
    chk("R5", "all banks on", bank_pwr, {NB{1'b1}});

    // power-down with ack high for a while, start during it ignored (R10)
    hs_rst_ack = 1;
    pulse(0, 1);
    repeat (40) @(negedge clk);
    pulse(1, 0);
    repeat (400) @(negedge clk);
    hs_rst_ack = 0;
    wait_idle();
    chk("R9", "down done", {done, subsys_rst, core_rst, hs_on}, 4'b1110);
    chk("R8", "banks off", bank_pwr, '0);
    chk("R7", "down clk io", {core_clk_en, io_clamp}, 2'b01);
    chk("R10", "start ignored during down", {xo_clk_en, core_clk_en, busy}, 3'b100);

    // stop during power-up is held
    pulse(1, 0);
    repeat (30) @(negedge clk);
    pulse(0, 1);
    wait_idle();
    chk("R10", "held stop ran down", {done, hs_on, core_rst, subsys_rst}, 4'b1011);

    // clock-off stuck: timeout on power-up
    clk_off = 1;
    pulse(1, 0);
    wait_idle();
    chk("R3", "xo poll timeout", {err, done, busy}, 3'b100);
    repeat (10) @(negedge clk);
    chk("R11", "held after error", {err, xo_clk_en, hs_on, subsys_rst}, 4'b1100);
    clk_off = 0;

    // ack stuck: timeout on power-down
    hs_rst_ack = 1;
    pulse(0, 1);
    wait_idle();
    chk("R9", "ack poll timeout", {err, busy, hs_on, subsys_rst}, 4'b1000);
    hs_rst_ack = 0;

    // both commands together: stop wins
    pulse(1, 1);
    wait_idle();
    chk("R11", "stop priority", {done, err, core_clk_en, subsys_rst, hs_on}, 5'b10010);

    // final clean power-up
    pulse(1, 0);
    wait_idle();
    chk("R2", "restart up", {done, subsys_rst, core_rst}, 3'b100);
    chk("R5", "banks on again", bank_pwr, {NB{1'b1}});
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule